// File: doc/BRIEF.md
# Sequential 16-by-16 Divider

This block divides a 16-bit dividend by a 16-bit divisor over a fixed number of clock cycles. The dividend comes from the accumulator-pair value and the divisor from an index-register value. When the operation ends, the quotient goes out on the index-side result port and the remainder on the accumulator-side result port, so the two results land in swapped registers compared with the operands.

Two modes share one restoring datapath. Integer mode gives the truncated quotient and the remainder of dividend / divisor. Fractional mode treats the dividend as a binary fraction below the divisor. It produces the 16-bit fraction (dividend * 65536) / divisor and the matching remainder. Three flags go out with each result: zero quotient, overflow and divide-by-zero. A one-cycle start request begins an operation. A one-cycle done pulse marks valid results, and the results then hold until the next done.

Top module: `div16_seq`

## Requirements
- R1: In integer mode (mode_frac = 0) with a nonzero divisor, quot_x = floor(dividend_d / divisor_x) and rem_d = dividend_d mod divisor_x.
- R2: In fractional mode (mode_frac = 1) with divisor_x > dividend_d, quot_x = floor(dividend_d * 65536 / divisor_x) and rem_d = (dividend_d * 65536) mod divisor_x.
- R3: When start is sampled high at a rising edge while the block is idle, done rises 41 rising edges later, in both modes.
- R4: done is high for exactly one cycle. quot_x, rem_d and the three flags keep their values from one done pulse to the next.
- R5: busy is high from the edge that accepts start until the edge that raises done. A start while busy is ignored: it neither changes the operands nor produces an extra result.
- R6: flag_zero is 1 exactly when the reported quot_x is 0x0000.
- R7: In integer mode flag_ovf is always 0.
- R8: In fractional mode with a nonzero divisor_x <= dividend_d, flag_ovf = 1, quot_x = 0xFFFF, rem_d = dividend_d and flag_dz = 0.
- R9: A zero divisor, in either mode, gives flag_dz = 1, quot_x = 0xFFFF, rem_d = dividend_d, flag_ovf = 0 and flag_zero = 0.
- R10: After a synchronous reset, busy, done, quot_x, rem_d and all flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division; sampled only while idle |
| mode_frac | input | 1 | 0 = integer mode, 1 = fractional mode |
| dividend_d | input | 16 | Dividend, sampled with start |
| divisor_x | input | 16 | Divisor, sampled with start |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the results are valid |
| quot_x | output | 16 | Quotient, to the index-side register |
| rem_d | output | 16 | Remainder, to the accumulator-side register |
| flag_zero | output | 1 | Quotient is zero |
| flag_ovf | output | 1 | Fractional overflow |
| flag_dz | output | 1 | Divide by zero |

## Verification
Integer divisions cover several cases that a shift or carry error would corrupt differently: a small exact case with a remainder, a full-scale dividend over one, equal operands, a dividend smaller than the divisor (zero quotient), and a zero dividend. Fractional divisions cover one half, one third (a repeating pattern with a remainder), a ratio just below one, a zero fraction, and the overflow edge where divisor equals dividend as well as where it is smaller. A zero divisor is tried in both modes. This separates the divide-by-zero override from the fractional overflow override. A start issued mid-operation with different operands checks that the running result is unaffected and that no second done appears. Every result is also compared against its exact arrival cycle.

// File: rtl/div16_pkg.sv
package div16_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned NUMW = 2 * DW;

  typedef struct packed {
    logic [DW-1:0] quot;
    logic [DW-1:0] rem;
    logic          zero;
    logic          ovf;
    logic          dz;
  } div_result_t;
endpackage

// File: rtl/div16_ctrl.sv
module div16_ctrl #(
  parameter int unsigned STEPS   = 32,
  parameter int unsigned LATENCY = 41
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic load,
  output logic step_en,
  output logic finish
);
  localparam int unsigned CW = $clog2(LATENCY + 1);

  logic [CW-1:0] cnt;

  assign load    = start && !busy;
  assign step_en = busy && (cnt < CW'(STEPS));
  assign finish  = busy && (cnt == CW'(LATENCY - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (finish) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !finish) |=> busy);

  // R5
  finish_ends_chk: assert property (@(posedge clk) disable iff (rst)
    finish |=> !busy);
endmodule

// File: rtl/div16_datapath.sv
module div16_datapath
  import div16_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step_en,
  input  logic          frac_in,
  input  logic [DW-1:0] d_in,
  input  logic [DW-1:0] x_in,
  output logic [NUMW-1:0] quot_raw,
  output logic [DW-1:0] rem_raw,
  output logic [DW-1:0] op_d,
  output logic [DW-1:0] op_x,
  output logic          op_frac
);
  logic [NUMW-1:0] num;
  logic [DW-1:0]   prem;
  logic [DW:0]     shifted;
  logic [DW+1:0]   trial;
  logic            qbit;

  always_comb begin
    shifted = {prem, num[NUMW-1]};
    trial   = {1'b0, shifted} - {2'b00, op_x};
    qbit    = !trial[DW+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      num     <= '0;
      prem    <= '0;
      op_d    <= '0;
      op_x    <= '0;
      op_frac <= 1'b0;
    end else if (load) begin
      num     <= frac_in ? {d_in, {DW{1'b0}}} : {{DW{1'b0}}, d_in};
      prem    <= '0;
      op_d    <= d_in;
      op_x    <= x_in;
      op_frac <= frac_in;
    end else if (step_en) begin
      num  <= {num[NUMW-2:0], qbit};
      prem <= qbit ? trial[DW-1:0] : shifted[DW-1:0];
    end
  end

  assign quot_raw = num;
  assign rem_raw  = prem;

  // R5
  op_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(op_x) && $stable(op_d) && $stable(op_frac)));
endmodule

// File: rtl/div16_result.sv
module div16_result
  import div16_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            finish,
  input  logic [NUMW-1:0] quot_raw,
  input  logic [DW-1:0]   rem_raw,
  input  logic [DW-1:0]   op_d,
  input  logic [DW-1:0]   op_x,
  input  logic            op_frac,
  output div_result_t     res,
  output logic            done
);
  div_result_t nxt;
  logic        is_dz;
  logic        is_ovf;

  always_comb begin
    is_dz  = (op_x == '0);
    is_ovf = op_frac && !is_dz && (op_x <= op_d);
    nxt.dz  = is_dz;
    nxt.ovf = is_ovf;
    if (is_dz || is_ovf) begin
      nxt.quot = '1;
      nxt.rem  = op_d;
    end else begin
      nxt.quot = quot_raw[DW-1:0];
      nxt.rem  = rem_raw;
    end
    nxt.zero = (nxt.quot == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res  <= '0;
      done <= 1'b0;
    end else begin
      done <= finish;
      if (finish) res <= nxt;
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !finish |=> $stable(res));

  // R7
  int_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !op_frac) |-> !res.ovf);

  // R9
  dz_result_chk: assert property (@(posedge clk) disable iff (rst)
    (done && res.dz) |-> (res.quot == '1 && res.rem == op_d && !res.ovf && !res.zero));
endmodule

// File: rtl/div16_seq.sv
module div16_seq
  import div16_pkg::*;
#(
  parameter int unsigned LATENCY = 41
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode_frac,
  input  logic [15:0]   dividend_d,
  input  logic [15:0]   divisor_x,
  output logic          busy,
  output logic          done,
  output logic [15:0]   quot_x,
  output logic [15:0]   rem_d,
  output logic          flag_zero,
  output logic          flag_ovf,
  output logic          flag_dz
);
  logic            load, step_en, finish, op_frac;
  logic [NUMW-1:0] quot_raw;
  logic [DW-1:0]   rem_raw, op_d, op_x;
  div_result_t     res;

  div16_ctrl #(.STEPS(NUMW), .LATENCY(LATENCY)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .load(load), .step_en(step_en), .finish(finish)
  );

  div16_datapath u_dp (
    .clk(clk), .rst(rst), .load(load), .step_en(step_en),
    .frac_in(mode_frac), .d_in(dividend_d), .x_in(divisor_x),
    .quot_raw(quot_raw), .rem_raw(rem_raw),
    .op_d(op_d), .op_x(op_x), .op_frac(op_frac)
  );

  div16_result u_res (
    .clk(clk), .rst(rst), .finish(finish),
    .quot_raw(quot_raw), .rem_raw(rem_raw),
    .op_d(op_d), .op_x(op_x), .op_frac(op_frac),
    .res(res), .done(done)
  );

  assign quot_x    = res.quot;
  assign rem_d     = res.rem;
  assign flag_zero = res.zero;
  assign flag_ovf  = res.ovf;
  assign flag_dz   = res.dz;

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(busy));
endmodule

// File: tb/test_div16_seq.sv
module test_div16_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mode_frac = 1'b0;
  logic [15:0] dividend_d = '0;
  logic [15:0] divisor_x = '0;
  logic        busy, done, flag_zero, flag_ovf, flag_dz;
  logic [15:0] quot_x, rem_d;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  typedef struct {
    logic [15:0] q;
    logic [15:0] r;
    logic        z, v, c;
    int          due;
  } exp_t;
  exp_t sb[$];

  div16_seq i_div16_seq (
    .clk(clk), .rst(rst), .start(start), .mode_frac(mode_frac),
    .dividend_d(dividend_d), .divisor_x(divisor_x), .busy(busy), .done(done),
    .quot_x(quot_x), .rem_d(rem_d), .flag_zero(flag_zero),
    .flag_ovf(flag_ovf), .flag_dz(flag_dz)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic run_op(input logic [15:0] d, input logic [15:0] x, input logic frac);
    exp_t e;
    logic [31:0] n;
    n = frac ? {d, 16'h0} : {16'h0, d};
    e.c = (x == 0);
    e.v = frac && x != 0 && x <= d;
    if (e.c || e.v) begin e.q = 16'hFFFF; e.r = d; end
    else begin e.q = 16'(n / {16'h0, x}); e.r = 16'(n % {16'h0, x}); end
    e.z = (e.q == 0);
    while (busy) @(negedge clk);
    e.due = cyc + 42;
    sb.push_back(e);
    dividend_d = d; divisor_x = x; mode_frac = frac; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor: R1 R2 R3 R6 R7 R8 R9 and R4 pulse width
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        chk("R5 extra done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk("R3 latency", cyc, e.due);
        chk("R1/R2 quotient", {16'h0, quot_x}, {16'h0, e.q});
        chk("R1/R2 remainder", {16'h0, rem_d}, {16'h0, e.r});
        chk("R6 zero", {31'h0, flag_zero}, {31'h0, e.z});
        chk("R7/R8 ovf", {31'h0, flag_ovf}, {31'h0, e.v});
        chk("R9 dz", {31'h0, flag_dz}, {31'h0, e.c});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] hq;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", {31'h0, busy}, 0);
    chk("R10 done", {31'h0, done}, 0);
    chk("R10 outputs", {quot_x, rem_d}, 0);
    chk("R10 flags", {29'h0, flag_zero, flag_ovf, flag_dz}, 0);
    // R1 integer patterns, R7 no overflow
    run_op(16'd100, 16'd7, 0);
    run_op(16'hFFFF, 16'd1, 0);
    run_op(16'hFFFF, 16'hFFFF, 0);
    run_op(16'd5, 16'd10, 0);
    run_op(16'd0, 16'd3, 0);
    // R9 zero divisor, integer
    run_op(16'd1234, 16'd0, 0);
    // R2 fractional patterns
    run_op(16'd1, 16'd2, 1);
    run_op(16'd1, 16'd3, 1);
    run_op(16'h7FFF, 16'h8000, 1);
    run_op(16'd0, 16'd9, 1);
    // R8 fractional overflow edges
    run_op(16'd5, 16'd5, 1);
    run_op(16'd6, 16'd5, 1);
    // R9 zero divisor, fractional
    run_op(16'd7, 16'd0, 1);
    // R5 start while busy is ignored
    run_op(16'd1000, 16'd33, 0);
    repeat (5) @(negedge clk);
    chk("R5 busy mid-op", {31'h0, busy}, 1);
    dividend_d = 16'd9; divisor_x = 16'd2; mode_frac = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    // R4 done is one cycle, results hold
    chk("R4 done width", {31'h0, done}, 0);
    hq = quot_x;
    repeat (60) @(negedge clk);
    chk("R4 quotient held", {16'h0, quot_x}, {16'h0, hq});
    chk("R5 no result for ignored start", sb.size(), 0);
    chk("R5 idle after ignored start", {31'h0, busy}, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule